// File: doc/BRIEF.md
# Programmable Colour Matrix with Key Gain

This block converts a stream of three-component video samples between colour spaces with a programmable 3x3 matrix. The three components are luma/green, blue-difference/blue and red-difference/red. A fourth component, the key, is scaled by its own gain and does not pass through the matrix. A per-channel offset is subtracted from each input before the matrix, and a per-channel offset is added to each result after it. With these two offset stages, a Y/Cb/Cr to R/G/B conversion followed by the inverse conversion returns the original codes. All products and sums are kept at full width, and the result is rounded only once. Each output is then saturated to a chosen word length.

Samples are 13-bit unsigned codes. Coefficients are 13-bit two's-complement values with 11 fractional bits, so the representable gains run from -2.0 to just under +2.0. Software loads the coefficients, offsets and mode through a single-cycle write port into a shadow bank. The shadow bank becomes active only when the frame-start strobe is high at a clock edge.

Samples enter and leave through valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. While the output is valid and not ready, the whole pipeline freezes and holds the presented sample. The input is ready exactly when the output register is empty or is being drained in that cycle. No sample is dropped or duplicated.

Top module: `csc_matrix_top`

## Requirements
- R1: When bypass is off, each colour output equals round(sum over j of C[i][j] * (x_j - ioff_j) / 2^11 + ooff_i), computed at full width with no intermediate truncation. C[i][j] is a 13-bit signed coefficient with 11 fractional bits. The order of i and j is Y=0, Cb=1, Cr=2.
- R2: Input offsets ioff_j are subtracted from the samples before the matrix. Output offsets ooff_i are added after the matrix and before rounding. Both offsets are 13-bit unsigned codes.
- R3: The key output equals round(kgain * key / 2^11). kgain is a 13-bit signed gain with 11 fractional bits, and no offset is applied to the key.
- R4: Mode bit 1 selects the rounding grid. With the bit set, results round half-up to a multiple of 8 (10-bit significance). With the bit clear, results round half-up to a multiple of 32 (8-bit significance). In both cases the rounding is a single step taken on the full-width sum.
- R5: Mode bits 3:2 select the clip limit. The value 0 limits results to [0, 8191], 1 limits them to [0, 8184], and 2 or 3 limits them to [0, 8160]. Negative results become 0, and results above the limit become the limit, with no wraparound. This applies to all four outputs.
- R6: When mode bit 0 (bypass) is set, all four outputs are bit-identical to the corresponding inputs, with the same latency as the processed path.
- R7: Register writes go to the shadow bank, and the active bank copies the whole shadow bank on a clock edge where frame_sync is high. The address map is: 0..8 for coefficient C[i][j] at address 3i+j, 9 for kgain, 10..12 for the input offsets (Y, Cb, Cr), 13..15 for the output offsets (Y, Cb, Cr), and 16 for the mode. Writes to addresses 17..31 change nothing.
- R8: If out_ready stays high, a sample accepted at clock edge n is presented with out_valid high after edge n+3. At most 4 samples are in flight at any time.
- R9: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low. Every accepted sample appears at the output exactly once and in order.
- R10: After reset, out_valid is low and in_ready is high. The active bank resets to an identity matrix with kgain 1.0, zero offsets, bypass on, 10-bit rounding and clip limit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 13 | Register write data |
| frame_sync | input | 1 | Copies the shadow bank into the active bank |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_y | input | 13 | Luma/green input |
| in_cb | input | 13 | Blue-difference/blue input |
| in_cr | input | 13 | Red-difference/red input |
| in_key | input | 13 | Key input |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the output sample |
| out_y | output | 13 | Luma/green result |
| out_cb | output | 13 | Blue-difference/blue result |
| out_cr | output | 13 | Red-difference/red result |
| out_key | output | 13 | Key result |

## Verification
The bench sweeps every 13-bit code through the luma and key channels under both the 8-bit rounding grid and bypass. A design that rounds twice, or that truncates a product, drifts by one grid step on these codes. Near-±2 coefficients and corner codes drive the sums far past both rails. A design that wraps instead of saturating shows near-zero values where the limit is expected. Shadow writes are made without a frame strobe, to catch a design that lets them go live early. Random back-pressure, and a long deliberate stall, expose a pipeline that drops, repeats or alters a held sample.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int DW     = 13;
  localparam int CW     = 13;
  localparam int FRAC   = 11;
  localparam int NCH    = 3;
  localparam int NCOEF  = NCH * NCH;
  localparam int LAT    = 4;
  localparam int AW     = 5;
  localparam int WL_MID = 10;
  localparam int WL_LOW = 8;
  localparam int DIFW   = DW + 1;
  localparam int PW     = DIFW + CW;
  localparam int SW     = PW + $clog2(NCH + 1) + 1;

  localparam int A_KEY  = NCOEF;
  localparam int A_IOFF = A_KEY + 1;
  localparam int A_OOFF = A_IOFF + NCH;
  localparam int A_MODE = A_OOFF + NCH;

  typedef struct packed {
    logic [NCOEF-1:0][CW-1:0] coef;
    logic [CW-1:0]            kgain;
    logic [NCH-1:0][DW-1:0]   ioff;
    logic [NCH-1:0][DW-1:0]   ooff;
    logic                     bypass;
    logic                     rnd10;
    logic [1:0]               clip;
  } cfg_t;

  function automatic cfg_t cfg_default();
    cfg_t c;
    c = '0;
    for (int i = 0; i < NCH; i++) c.coef[i*NCH+i] = CW'(1 << FRAC);
    c.kgain  = CW'(1 << FRAC);
    c.bypass = 1'b1;
    c.rnd10  = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  input  logic          frame_sync,
  output cfg_t          act
);
  localparam int IW = $clog2(NCOEF);
  localparam int NW = $clog2(NCH);

  cfg_t shd;

  // shadow bank: written any time, never seen by the datapath directly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= cfg_default();
    end else if (we) begin
      if (addr < AW'(A_KEY))
        shd.coef[IW'(addr)] <= wdata;
      else if (addr == AW'(A_KEY))
        shd.kgain <= wdata;
      else if (addr < AW'(A_OOFF))
        shd.ioff[NW'(addr - AW'(A_IOFF))] <= wdata[DW-1:0];
      else if (addr < AW'(A_MODE))
        shd.ooff[NW'(addr - AW'(A_OOFF))] <= wdata[DW-1:0];
      else if (addr == AW'(A_MODE))
        {shd.clip, shd.rnd10, shd.bypass} <= wdata[3:0];
    end
  end

  // active bank: whole-bank copy at the frame strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act <= cfg_default();
    else if (frame_sync) act <= shd;
  end
endmodule

// File: rtl/csc_dot.sv
module csc_dot
  import csc_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic                      clk,
  input  logic                      ce,
  input  logic [N-1:0][DIFW-1:0]    d,
  input  logic [N-1:0][CW-1:0]      c,
  input  logic signed [SW-1:0]      bias,
  output logic signed [SW-1:0]      acc
);
  logic signed [PW-1:0] prod_q [N];
  logic signed [SW-1:0] bias_q;
  logic signed [SW-1:0] sum_c;

  // stage A: full-width products
  always_ff @(posedge clk) begin
    if (ce) begin
      for (int i = 0; i < N; i++)
        prod_q[i] <= PW'($signed(d[i])) * PW'($signed(c[i]));
      bias_q <= bias;
    end
  end

  always_comb begin
    sum_c = bias_q;
    for (int i = 0; i < N; i++) sum_c = sum_c + SW'(prod_q[i]);
  end

  // stage B: full-width sum, bias already aligned to the product scale
  always_ff @(posedge clk) begin
    if (ce) acc <= sum_c;
  end
endmodule

// File: rtl/csc_rclip.sv
module csc_rclip
  import csc_pkg::*;
(
  input  logic signed [SW-1:0] acc,
  input  logic                 rnd10,
  input  logic [1:0]           clip,
  output logic [DW-1:0]        res
);
  localparam int DM = DW - WL_MID;
  localparam int DL = DW - WL_LOW;
  localparam logic signed [SW-1:0] HALF_M = SW'(1 << (FRAC + DM - 1));
  localparam logic signed [SW-1:0] HALF_L = SW'(1 << (FRAC + DL - 1));
  localparam logic signed [SW-1:0] MAX_F  = SW'((1 << DW) - 1);
  localparam logic signed [SW-1:0] MAX_M  = SW'(((1 << DW) - 1) & ~((1 << DM) - 1));
  localparam logic signed [SW-1:0] MAX_L  = SW'(((1 << DW) - 1) & ~((1 << DL) - 1));

  logic signed [SW-1:0] rm, rl, val, lim;

  always_comb begin
    rm  = (acc + HALF_M) >>> (FRAC + DM);
    rl  = (acc + HALF_L) >>> (FRAC + DL);
    val = rnd10 ? (rm <<< DM) : (rl <<< DL);
    case (clip)
      2'd0:    lim = MAX_F;
      2'd1:    lim = MAX_M;
      default: lim = MAX_L;
    endcase
    if (val < 0)        res = '0;
    else if (val > lim) res = lim[DW-1:0];
    else                res = val[DW-1:0];
  end
endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
  import csc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [12:0]   cfg_wdata,
  input  logic          frame_sync,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [12:0]   in_y,
  input  logic [12:0]   in_cb,
  input  logic [12:0]   in_cr,
  input  logic [12:0]   in_key,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [12:0]   out_y,
  output logic [12:0]   out_cb,
  output logic [12:0]   out_cr,
  output logic [12:0]   out_key
);
  localparam int NW = NCH + 1;  // colour channels plus key

  cfg_t act;

  csc_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .frame_sync (frame_sync),
    .act        (act)
  );

  // one enable for every stage: the pipe moves unless the output is stuck
  logic           ce;
  logic [LAT-1:0] v_q;

  assign ce        = !v_q[LAT-1] || out_ready;
  assign in_ready  = ce;
  assign out_valid = v_q[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  v_q <= '0;
    else if (ce) v_q <= {v_q[LAT-2:0], in_valid};
  end

  logic [NW-1:0][DW-1:0] in_w;
  assign in_w = {in_key, in_cr, in_cb, in_y};

  // stage 1: input offsets
  logic [NCH-1:0][DIFW-1:0] dif_q;
  logic [0:0][DIFW-1:0]     kd_q;

  always_ff @(posedge clk) begin
    if (ce) begin
      for (int ch = 0; ch < NCH; ch++)
        dif_q[ch] <= {1'b0, in_w[ch]} - {1'b0, act.ioff[ch]};
      kd_q[0] <= {1'b0, in_key};
    end
  end

  // raw copy for the bypass path, aligned to stage 3
  logic [LAT-2:0][NW-1:0][DW-1:0] raw_q;

  always_ff @(posedge clk) begin
    if (ce) raw_q <= {raw_q[LAT-3:0], in_w};
  end

  // stages 2 and 3: products and sums
  logic signed [SW-1:0] acc_w  [NW];
  logic signed [SW-1:0] bias_w [NCH];

  for (genvar r = 0; r < NCH; r++) begin : g_row
    assign bias_w[r] = $signed({{(SW-DW-FRAC){1'b0}}, act.ooff[r], {FRAC{1'b0}}});
    csc_dot #(.N(NCH)) u_dot (
      .clk  (clk),
      .ce   (ce),
      .d    (dif_q),
      .c    (act.coef[r*NCH +: NCH]),
      .bias (bias_w[r]),
      .acc  (acc_w[r])
    );
  end

  csc_dot #(.N(1)) u_key (
    .clk  (clk),
    .ce   (ce),
    .d    (kd_q),
    .c    (act.kgain),
    .bias ('0),
    .acc  (acc_w[NCH])
  );

  // stage 4: single rounding, clipping, bypass select
  logic [DW-1:0]         rc_res [NW];
  logic [NW-1:0][DW-1:0] out_q;

  for (genvar ch = 0; ch < NW; ch++) begin : g_ch
    csc_rclip u_rc (
      .acc   (acc_w[ch]),
      .rnd10 (act.rnd10),
      .clip  (act.clip),
      .res   (rc_res[ch])
    );
    always_ff @(posedge clk) begin
      if (ce) out_q[ch] <= act.bypass ? raw_q[LAT-2][ch] : rc_res[ch];
    end
  end

  assign out_y   = out_q[0];
  assign out_cb  = out_q[1];
  assign out_cr  = out_q[2];
  assign out_key = out_q[3];
endmodule

// File: rtl/csc_checker.sv
module csc_checker
  import csc_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [NCH:0][DW-1:0]   out_w,
  input logic                   frame_sync,
  input cfg_t                   act,
  input logic                   v3,
  input logic [DW-1:0]          rc0,
  input logic [1:0]             clip
);
  logic [3:0]    infl;
  logic [DW-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) infl <= '0;
    else        infl <= infl + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
  end

  always_comb begin
    case (clip)
      2'd0:    lim = '1;
      2'd1:    lim = {{WL_MID{1'b1}}, {(DW-WL_MID){1'b0}}};
      default: lim = {{WL_LOW{1'b1}}, {(DW-WL_LOW){1'b0}}};
    endcase
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_w));

  assert_occupancy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    infl <= 4'(LAT));

  assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(act));

  assert_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v3 |-> rc0 <= lim);
endmodule

bind csc_matrix_top csc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_w      (out_q),
  .frame_sync (frame_sync),
  .act        (act),
  .v3         (v_q[2]),
  .rc0        (rc_res[0]),
  .clip       (act.clip)
);

// File: tb/tb_csc_matrix_top.sv
`timescale 1ns/1ps
module tb_csc_matrix_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic        frame_sync = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_y = '0, in_cb = '0, in_cr = '0, in_key = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [12:0] out_y, out_cb, out_cr, out_key;

  always #2.5 clk = ~clk;

  csc_matrix_top dut (.*);

  int checks = 0;
  int errors = 0;

  int s_c[9], m_c[9], s_io[3], m_io[3], s_oo[3], m_oo[3];
  int s_k, m_k, s_byp, m_byp, s_r10, m_r10, s_clip, m_clip;

  logic [51:0] exp_q[$];
  int unsigned lf = 32'h1234_5678;

  function automatic int unsigned nxt();
    lf ^= lf << 13;
    lf ^= lf >> 17;
    lf ^= lf << 5;
    return lf;
  endfunction

  function automatic int fin(longint acc);
    int drop, sh, mx;
    longint r, v;
    drop = m_r10 ? 3 : 5;
    sh   = 11 + drop;
    r    = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    v    = r * (longint'(1) << drop);
    mx   = (m_clip == 0) ? 8191 : (m_clip == 1) ? 8184 : 8160;
    if (v < 0) return 0;
    if (v > mx) return mx;
    return int'(v);
  endfunction

  function automatic logic [51:0] model(input int x[4]);
    int o[4];
    longint acc;
    if (m_byp != 0) return {13'(x[3]), 13'(x[2]), 13'(x[1]), 13'(x[0])};
    for (int i = 0; i < 3; i++) begin
      acc = longint'(m_oo[i]) * 2048;
      for (int j = 0; j < 3; j++) acc += longint'(m_c[i*3+j]) * longint'(x[j] - m_io[j]);
      o[i] = fin(acc);
    end
    o[3] = fin(longint'(m_k) * longint'(x[3]));
    return {13'(o[3]), 13'(o[2]), 13'(o[1]), 13'(o[0])};
  endfunction

  task automatic chk_word(input string tag, input logic [51:0] got, input logic [51:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got y=%0d cb=%0d cr=%0d key=%0d exp y=%0d cb=%0d cr=%0d key=%0d",
               tag, got[12:0], got[25:13], got[38:26], got[51:39],
               exp[12:0], exp[25:13], exp[38:26], exp[51:39]);
    end
  endtask

  task automatic chk_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 13'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 9) s_c[a] = v;
    else if (a == 9) s_k = v;
    else if (a < 13) s_io[a-10] = v;
    else if (a < 16) s_oo[a-13] = v;
    else if (a == 16) begin s_byp = v & 1; s_r10 = (v >> 1) & 1; s_clip = (v >> 2) & 3; end
  endtask

  task automatic wr_mode(input int byp, input int r10, input int clp);
    wr(16, (clp << 2) | (r10 << 1) | byp);
  endtask

  task automatic fsync();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    m_c = s_c; m_io = s_io; m_oo = s_oo; m_k = s_k;
    m_byp = s_byp; m_r10 = s_r10; m_clip = s_clip;
  endtask

  task automatic set_coefs(input int c[9]);
    for (int i = 0; i < 9; i++) wr(i, c[i]);
  endtask

  function automatic int corner(int k);
    int tbl[9] = '{0, 1, 2, 8191, 8190, 4096, 4095, 64, 7520};
    return tbl[k % 9];
  endfunction

  task automatic gen(input int pat, input int n, output int x[4]);
    if (pat == 0) begin
      for (int c = 0; c < 4; c++) x[c] = int'(nxt() % 8192);
    end else if (pat == 1) begin
      x[0] = n % 8192; x[1] = 8191 - (n % 8192); x[2] = (n * 37) % 8192; x[3] = n % 8192;
    end else begin
      for (int c = 0; c < 4; c++) x[c] = corner(n + c * 4);
    end
  endtask

  task automatic run(input int n, input int pat, input int vrand, input int rrand, input string tag);
    int sent = 0;
    int guard = 0;
    int x[4];
    logic [51:0] e;
    while ((sent < n || exp_q.size() > 0) && guard < 40000) begin
      @(negedge clk);
      guard++;
      in_valid = (sent < n) && (vrand == 0 || (nxt() % 4 != 0));
      gen(pat, sent, x);
      in_y = 13'(x[0]); in_cb = 13'(x[1]); in_cr = 13'(x[2]); in_key = 13'(x[3]);
      out_ready = (rrand == 0) || (nxt() % 3 != 0);
      #1;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(x));
        sent++;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk_word({tag, " R9 extra sample"}, {out_key, out_cr, out_cb, out_y}, 'x);
        else begin
          e = exp_q.pop_front();
          chk_word(tag, {out_key, out_cr, out_cb, out_y}, e);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 %s lost samples got %0d pending exp 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic latency(input string tag);
    int x[4] = '{1000, 3000, 5000, 777};
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    in_y = 13'(x[0]); in_cb = 13'(x[1]); in_cr = 13'(x[2]); in_key = 13'(x[3]);
    @(negedge clk); in_valid = 1'b0;
    chk_bit({tag, " R8 not early at +1"}, out_valid, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk_bit({tag, " R8 not early at +3"}, out_valid, 1'b0);
    @(negedge clk);
    chk_bit({tag, " R8 valid at +4"}, out_valid, 1'b1);
    chk_word({tag, " R8 data"}, {out_key, out_cr, out_cb, out_y}, model(x));
    @(negedge clk);
    chk_bit({tag, " R8 drained"}, out_valid, 1'b0);
  endtask

  task automatic hold_test();
    int x[4];
    logic [51:0] first;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1;
      gen(2, i, x);
      in_y = 13'(x[0]); in_cb = 13'(x[1]); in_cr = 13'(x[2]); in_key = 13'(x[3]);
      #1;
      if (in_ready) exp_q.push_back(model(x));
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk_bit("R9 stalled output valid", out_valid, 1'b1);
    chk_bit("R9 in_ready low while stalled", in_ready, 1'b0);
    first = {out_key, out_cr, out_cb, out_y};
    repeat (4) @(negedge clk);
    chk_word("R9 held output stable", {out_key, out_cr, out_cb, out_y}, first);
    chk_word("R9 held output value", first, exp_q[0]);
    run(0, 0, 0, 1, "R9 drain after stall");
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog got running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c[9];
    for (int i = 0; i < 9; i++) s_c[i] = (i % 4 == 0) ? 2048 : 0;
    s_io = '{0, 0, 0}; s_oo = '{0, 0, 0}; s_k = 2048;
    s_byp = 1; s_r10 = 1; s_clip = 0;
    m_c = s_c; m_io = s_io; m_oo = s_oo; m_k = s_k;
    m_byp = s_byp; m_r10 = s_r10; m_clip = s_clip;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R10 out_valid after reset", out_valid, 1'b0);
    chk_bit("R10 in_ready after reset", in_ready, 1'b1);
    run(40, 2, 0, 0, "R10 reset defaults bypass");
    latency("R6 bypass");

    wr_mode(0, 1, 0); fsync();
    latency("R1 processed");
    run(300, 0, 1, 1, "R1 identity");

    // shadow writes must stay invisible until the frame strobe
    wr(0, -2048); wr(4, 1024); wr(20, 4095); wr(31, 77);
    run(60, 0, 0, 0, "R7 shadow not yet live");
    fsync();
    run(60, 0, 0, 0, "R7 after frame_sync");

    c = '{1500, -700, 300, -1200, 2047, -2048, 4095, -4096, 10};
    set_coefs(c); fsync();
    run(300, 0, 1, 1, "R1 mixed matrix");

    c = '{2384, 0, 3269, 2384, -401, -833, 2384, 4095, 0};
    set_coefs(c); wr(10, 512); wr(11, 4096); wr(12, 4096); fsync();
    run(300, 0, 1, 1, "R2 input offsets");
    c = '{526, 1033, 200, -303, -596, 899, 899, -753, -146};
    set_coefs(c); wr(10, 0); wr(11, 0); wr(12, 0);
    wr(13, 512); wr(14, 4096); wr(15, 4096); fsync();
    run(300, 0, 1, 1, "R2 output offsets");

    c = '{2048, 0, 0, 0, 2048, 0, 0, 0, 2048};
    set_coefs(c); wr(13, 0); wr(14, 0); wr(15, 0);
    wr_mode(0, 0, 2); fsync();
    run(8192, 1, 0, 1, "R4 8-bit grid sweep");
    wr_mode(0, 1, 0); fsync();
    run(8192, 1, 0, 1, "R4 10-bit grid sweep");

    wr(9, 3001); fsync();
    run(200, 2, 1, 1, "R3 key gain above one");
    wr(9, -1500); fsync();
    run(100, 0, 0, 0, "R3 key gain negative");

    c = '{4095, 4095, 0, -4096, 0, 0, 0, 1, -4096};
    set_coefs(c); wr(10, 100); wr(11, 0); wr(12, 0); wr(9, 4095);
    wr_mode(0, 1, 1); fsync();
    run(200, 2, 0, 0, "R5 clip 10-bit limit");
    wr_mode(0, 1, 0); fsync();
    run(200, 0, 1, 1, "R5 clip full limit");
    wr_mode(0, 1, 3); fsync();
    run(200, 2, 1, 0, "R5 clip 8-bit limit");

    wr_mode(1, 0, 2); fsync();
    run(8192, 1, 1, 1, "R6 bypass sweep");
    run(100, 2, 0, 1, "R6 bypass corners");

    wr_mode(0, 1, 0); fsync();
    hold_test();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule